// File: doc/BRIEF.md
# External Bus Yield Controller

This block sits on the master side of an external memory bus and lends that bus to an outside agent on request. The agent raises a request line. At a bus-cycle boundary the controller first blocks new strobes for one cycle. It then turns off its control, address and data drivers and raises an acknowledge. When the agent drops its request, the controller withdraws the acknowledge. If the request stays low long enough, it turns the drivers back on, and only after that lets the memory controller start a new cycle.

A refresh request that arrives while the bus is lent out withdraws the acknowledge at once, even though the agent still holds its request. This tells the agent to give the bus back. A refresh-pending flag then stays high until the refresh logic reports that it has begun, so the refresh wins over ordinary traffic once the bus is back. Lending is gated by an enable input. A standby input blocks both lending and the forced reclaim.

Top module: `bus_yield_ctrl`

## Requirements
- R1: After reset, all three driver enables are 1, the acknowledge is 0, cycle-start permission is 1 and refresh pending is 0.
- R2: The request is sampled on rising edges only. When a release is granted, cycle-start permission drops one cycle before the driver enables drop. The acknowledge rises together with the drivers going off.
- R3: At the first rising edge that samples the request low while the acknowledge is high, the acknowledge goes to 0.
- R4: The driver enables return at a rising edge, and cycle-start permission returns at that same edge. A new strobe may therefore be issued no earlier than the following edge. Permission is never 1 while the drivers are off.
- R5: The drivers return only after the request has been sampled low on MIN_NEG (default 2) consecutive edges. If the request is high again before that, the acknowledge comes back and the drivers stay off.
- R6: A refresh request sampled while the bus is lent out sets refresh pending and clears the acknowledge at that edge, even if the request is still high.
- R7: With the enable input at 0, the request is ignored: the drivers stay on and the acknowledge stays 0.
- R8: While standby is 1, no release is granted and refresh pending is not set.
- R9: A release is granted only at an edge where the memory idle input is 1. While refresh pending is 1, no release is granted.
- R10: Refresh pending clears only at an edge where the refresh-start input is 1 and cycle-start permission is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| reqEnable | input | 1 | 1 allows the bus to be lent out |
| standby | input | 1 | 1 blocks lending and the forced reclaim |
| memIdle | input | 1 | 1 when the memory controller is between bus cycles |
| slaveReq | input | 1 | Bus request from the outside agent, active high |
| refreshReq | input | 1 | Refresh wanted, from the refresh timer |
| refreshStart | input | 1 | Refresh logic has begun its refresh |
| slaveAck | output | 1 | Bus lent to the agent, active high |
| ctrlOe | output | 1 | Control strobe driver enable |
| addrOe | output | 1 | Address driver enable |
| dataOe | output | 1 | Data driver enable |
| cycleOk | output | 1 | Memory controller may issue strobes from the next edge |
| refreshPending | output | 1 | Refresh must run before other accesses |

## Verification
The bench goes after a request that drops for a single cycle. A design that counts one low sample as enough would turn its drivers on while the agent still drives the bus. It raises refresh while the agent holds the bus, where a design that waits for the request to fall would never reclaim the bus in time. It also toggles the enable, standby and idle inputs around request edges. A design that samples those at the wrong edge would float the bus in the middle of an access or while in standby.

// File: rtl/bus_yield_pkg.sv
package bus_yield_pkg;
  typedef enum logic [2:0] {
    ST_OWNED, ST_STROBE_NEGATE, ST_RELEASED, ST_REDRIVE, ST_READY
  } yield_state_t;

  typedef struct packed {
    logic drive;      // drivers enabled in the coming cycle
    logic grant;      // bus lent out in the coming cycle
    logic allowCycle; // memory controller may launch
    logic inReleased; // current state is released
  } yield_strobes_t;
endpackage

// File: rtl/bus_yield_fsm.sv
module bus_yield_fsm
  import bus_yield_pkg::*;
#(
  parameter int MIN_NEG = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           slaveReq,
  input  logic           reqEnable,
  input  logic           standby,
  input  logic           memIdle,
  input  logic           pendQ,
  output yield_strobes_t strb
);
  localparam int CW = $clog2(MIN_NEG + 1);
  localparam logic [CW-1:0] NEG_LIMIT = CW'(MIN_NEG);

  yield_state_t state, nextState;
  logic [CW-1:0] negCnt, nextCnt;

  always_comb begin
    nextState = state;
    nextCnt   = negCnt;
    unique case (state)
      ST_OWNED:
        if (slaveReq && reqEnable && !standby && memIdle && !pendQ)
          nextState = ST_STROBE_NEGATE;
      ST_STROBE_NEGATE: nextState = ST_RELEASED;
      ST_RELEASED:
        if (!slaveReq) begin
          nextState = ST_REDRIVE;
          nextCnt   = CW'(1);
        end
      ST_REDRIVE:
        if (slaveReq) begin
          nextState = ST_RELEASED;
        end else if (negCnt + CW'(1) >= NEG_LIMIT) begin
          nextState = ST_READY;
        end else begin
          nextCnt = negCnt + CW'(1);
        end
      ST_READY: nextState = ST_OWNED;
      default:  nextState = ST_OWNED;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_OWNED;
      negCnt <= '0;
    end else begin
      state  <= nextState;
      negCnt <= nextCnt;
    end
  end

  always_comb begin
    strb.drive      = (nextState == ST_OWNED) || (nextState == ST_STROBE_NEGATE) ||
                      (nextState == ST_READY);
    strb.grant      = (nextState == ST_RELEASED);
    strb.allowCycle = (nextState == ST_OWNED) || (nextState == ST_READY);
    strb.inReleased = (state == ST_RELEASED);
  end
endmodule

// File: rtl/bus_yield_regs.sv
module bus_yield_regs
  import bus_yield_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  yield_strobes_t strb,
  input  logic           refreshReq,
  input  logic           refreshStart,
  input  logic           standby,
  output logic           ackQ,
  output logic           ctrlOeQ,
  output logic           addrOeQ,
  output logic           dataOeQ,
  output logic           cycleOkQ,
  output logic           pendQ
);
  logic pendNext;

  always_comb begin
    if (pendQ) pendNext = !(refreshStart && cycleOkQ);
    else       pendNext = strb.inReleased && refreshReq && !standby;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackQ     <= 1'b0;
      ctrlOeQ  <= 1'b1;
      addrOeQ  <= 1'b1;
      dataOeQ  <= 1'b1;
      cycleOkQ <= 1'b1;
      pendQ    <= 1'b0;
    end else begin
      ackQ     <= strb.grant && !pendNext;
      ctrlOeQ  <= strb.drive;
      addrOeQ  <= strb.drive;
      dataOeQ  <= strb.drive;
      cycleOkQ <= strb.allowCycle;
      pendQ    <= pendNext;
    end
  end
endmodule

// File: rtl/bus_yield_ctrl.sv
module bus_yield_ctrl
  import bus_yield_pkg::*;
#(
  parameter int MIN_NEG = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqEnable,
  input  logic standby,
  input  logic memIdle,
  input  logic slaveReq,
  input  logic refreshReq,
  input  logic refreshStart,
  output logic slaveAck,
  output logic ctrlOe,
  output logic addrOe,
  output logic dataOe,
  output logic cycleOk,
  output logic refreshPending
);
  yield_strobes_t strb;
  logic pendQ;

  bus_yield_fsm #(.MIN_NEG(MIN_NEG)) u_fsm (
    .clk(clk), .rstN(rstN), .slaveReq(slaveReq), .reqEnable(reqEnable),
    .standby(standby), .memIdle(memIdle), .pendQ(pendQ), .strb(strb)
  );

  bus_yield_regs u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .refreshReq(refreshReq),
    .refreshStart(refreshStart), .standby(standby), .ackQ(slaveAck),
    .ctrlOeQ(ctrlOe), .addrOeQ(addrOe), .dataOeQ(dataOe),
    .cycleOkQ(cycleOk), .pendQ(pendQ)
  );

  assign refreshPending = pendQ;
endmodule

// File: rtl/bus_yield_checker.sv
module bus_yield_checker #(
  parameter int MIN_NEG = 2
) (
  input logic clk,
  input logic rstN,
  input logic reqEnable,
  input logic standby,
  input logic memIdle,
  input logic slaveReq,
  input logic refreshReq,
  input logic refreshStart,
  input logic slaveAck,
  input logic ctrlOe,
  input logic addrOe,
  input logic dataOe,
  input logic cycleOk,
  input logic refreshPending
);
  localparam int CW = $clog2(MIN_NEG + 1);
  logic [CW-1:0] lowRun;

  // saturating count of consecutive low request samples
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lowRun <= '0;
    else if (slaveReq) lowRun <= '0;
    else if (lowRun < CW'(MIN_NEG)) lowRun <= lowRun + CW'(1);
  end

  p_negate_before_float_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctrlOe) |-> !$past(cycleOk));
  p_ack_only_floating_r2: assert property (@(posedge clk) disable iff (!rstN)
    slaveAck |-> (!ctrlOe && !addrOe && !dataOe));
  p_ack_drops_on_negate_r3: assert property (@(posedge clk) disable iff (!rstN)
    (slaveAck && !slaveReq) |=> !slaveAck);
  p_no_cycle_while_float_r4: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlOe |-> !cycleOk);
  p_permit_with_drive_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cycleOk) |-> $rose(ctrlOe));
  p_long_negation_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlOe) |-> (lowRun >= CW'(MIN_NEG)));
  p_refresh_reclaim_r6: assert property (@(posedge clk) disable iff (!rstN)
    (refreshReq && slaveAck && !standby) |=> (!slaveAck && refreshPending));
  p_enable_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cycleOk) |-> $past(reqEnable));
  p_standby_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cycleOk) |-> !$past(standby));
  p_standby_refresh_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(refreshPending) |-> !$past(standby));
  p_idle_boundary_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cycleOk) |-> $past(memIdle));
  p_pending_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(refreshPending) |-> ($past(refreshStart) && $past(cycleOk)));
endmodule

bind bus_yield_ctrl bus_yield_checker #(.MIN_NEG(MIN_NEG)) u_chk (
  .clk(clk), .rstN(rstN), .reqEnable(reqEnable), .standby(standby),
  .memIdle(memIdle), .slaveReq(slaveReq), .refreshReq(refreshReq),
  .refreshStart(refreshStart), .slaveAck(slaveAck), .ctrlOe(ctrlOe),
  .addrOe(addrOe), .dataOe(dataOe), .cycleOk(cycleOk),
  .refreshPending(refreshPending)
);

// File: tb/sim_bus_yield_ctrl.sv
module sim_bus_yield_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqEnable = 1'b1, standby = 1'b0, memIdle = 1'b1, slaveReq = 1'b0;
  logic refreshReq = 1'b0, refreshStart = 1'b0;
  logic slaveAck, ctrlOe, addrOe, dataOe, cycleOk, refreshPending;

  int nTests = 0, nFail = 0;
  int cycles = 0;
  bit finished = 1'b0;

  // reference model: 0 own, 1 negate, 2 lent, 3 redrive, 4 ready
  int mSt = 0;
  int mCnt = 0;
  bit mPend = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  bus_yield_ctrl u0 (
    .clk(clk), .rstN(rstN), .reqEnable(reqEnable), .standby(standby),
    .memIdle(memIdle), .slaveReq(slaveReq), .refreshReq(refreshReq),
    .refreshStart(refreshStart), .slaveAck(slaveAck), .ctrlOe(ctrlOe),
    .addrOe(addrOe), .dataOe(dataOe), .cycleOk(cycleOk),
    .refreshPending(refreshPending)
  );

  function automatic bit expDrive(int s);
    return (s == 0) || (s == 1) || (s == 4);
  endfunction
  function automatic bit expPermit(int s);
    return (s == 0) || (s == 4);
  endfunction
  function automatic bit expAck(int s, bit p);
    return (s == 2) && !p;
  endfunction

  task automatic check(input bit act, input bit exp, input string tag);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0b expected %0b at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic modelStep();
    int ns = mSt;
    bit np = mPend;
    if (mPend) np = !(refreshStart && expPermit(mSt));
    else np = (mSt == 2) && refreshReq && !standby;
    case (mSt)
      0: if (slaveReq && reqEnable && !standby && memIdle && !mPend) ns = 1;
      1: ns = 2;
      2: if (!slaveReq) begin ns = 3; mCnt = 1; end
      3: if (slaveReq) ns = 2;
         else if (mCnt + 1 >= 2) ns = 4;
         else mCnt++;
      default: ns = 0;
    endcase
    mSt = ns;
    mPend = np;
  endtask

  task automatic compareAll();
    check(ctrlOe, expDrive(mSt), "R2 ctrlOe");
    check(addrOe, expDrive(mSt), "R2 addrOe");
    check(dataOe, expDrive(mSt), "R2 dataOe");
    check(slaveAck, expAck(mSt, mPend), "R3 slaveAck");
    check(cycleOk, expPermit(mSt), "R4 cycleOk");
    check(refreshPending, mPend, "R10 refreshPending");
  endtask

  // one clock: model follows the edge, outputs compared at the falling edge
  task automatic tick();
    @(posedge clk);
    modelStep();
    cycles++;
    @(negedge clk);
    compareAll();
  endtask

  task automatic setIn(bit en, bit sb, bit idle, bit req, bit rr, bit rs);
    reqEnable = en; standby = sb; memIdle = idle; slaveReq = req;
    refreshReq = rr; refreshStart = rs;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(ctrlOe && addrOe && dataOe, 1'b1, "R1 drivers on");
    check(slaveAck, 1'b0, "R1 ack low");
    check(cycleOk, 1'b1, "R1 permit high");
    check(refreshPending, 1'b0, "R1 pending low");
    rstN = 1'b1;

    // R2: normal release sequence
    setIn(1, 0, 1, 1, 0, 0); tick();
    check(cycleOk, 1'b0, "R2 permit drops first");
    check(ctrlOe, 1'b1, "R2 drivers still on");
    tick();
    check(slaveAck, 1'b1, "R2 ack with float");
    tick();
    // R5: one-cycle negation must not redrive
    setIn(1, 0, 1, 0, 0, 0); tick();
    check(slaveAck, 1'b0, "R3 ack drops at negation");
    check(ctrlOe, 1'b0, "R3 no drive at negation edge");
    setIn(1, 0, 1, 1, 0, 0); tick();
    check(ctrlOe, 1'b0, "R5 short negation keeps float");
    check(slaveAck, 1'b1, "R5 ack returns");
    // R6: refresh while lent
    setIn(1, 0, 1, 1, 1, 0); tick();
    check(slaveAck, 1'b0, "R6 ack withdrawn");
    check(refreshPending, 1'b1, "R6 pending set");
    setIn(1, 0, 1, 0, 0, 0); tick(); tick();
    check(ctrlOe, 1'b1, "R4 drive after two lows");
    check(cycleOk, 1'b1, "R4 permit with drive");
    // R9: pending blocks a new release
    setIn(1, 0, 1, 1, 0, 0); tick(); tick();
    check(cycleOk, 1'b1, "R9 pending blocks release");
    // R10: clears on start
    setIn(1, 0, 1, 0, 0, 1); tick();
    check(refreshPending, 1'b0, "R10 pending cleared");
    // R7: enable low ignores request
    setIn(0, 0, 1, 1, 0, 0); tick(); tick(); tick();
    check(ctrlOe && !slaveAck, 1'b1, "R7 request ignored");
    // R8: standby blocks release
    setIn(1, 1, 1, 1, 0, 0); tick(); tick(); tick();
    check(ctrlOe && !slaveAck, 1'b1, "R8 standby holds bus");
    // R9: busy memory blocks release
    setIn(1, 0, 0, 1, 0, 0); tick(); tick();
    check(cycleOk, 1'b1, "R9 busy holds bus");
    setIn(1, 0, 1, 0, 0, 0); tick();

    // random phase
    for (int i = 0; i < 4000; i++) begin
      setIn(($urandom % 8) != 0, ($urandom % 10) == 0, ($urandom % 4) != 0,
            ($urandom % 3) != 0, ($urandom % 12) == 0, ($urandom % 3) == 0);
      tick();
    end
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule